// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Domain Fill Level

This block buffers fixed-width words between a producer and a consumer that run on unrelated clocks. Storage is a circular register file. The write side and the read side each keep their own position counter. Each counter is held in both binary and reflected-binary (Gray) form. The Gray form is registered and then carried into the opposite clock domain through a synchronizer chain of configurable length.

Each domain converts the incoming Gray pointer back to binary. It subtracts that value from its own binary pointer, or subtracts its own pointer from it, modulo twice the depth. The result is a fill count local to that domain. From this count each side decodes its own set of flags: empty, almost-empty, half-full, almost-full and full.

Because the remote pointer arrives late, the write side may report more occupancy than is really present, and the read side may report less. Neither side can therefore overrun or underrun the storage. A write while the write side shows full is dropped. A read while the read side shows empty is dropped. The oldest word is always presented on the read data port, and a read pops it.

Top module: `dcfifo_lvl`

## Requirements
- R1: After both domain resets, each side reports level 0 with its empty and almost-empty flags high and its full, almost-full and half-full flags low.
- R2: Every accepted word leaves the read data port exactly once, in the order it was written, with no value altered.
- R3: A write request while `wr_full` is high changes no state: the write level stays at the depth, and no extra word is ever delivered.
- R4: A read request while `rd_empty` is high changes no state: the read level stays 0, and the next word written is the next word read.
- R5: Each level is `ADDR_W+1` bits wide and never exceeds DEPTH = 2^ADDR_W. The full flag of a side is the top bit of that side's level.
- R6: Once both ports have been idle for longer than the synchronizer latency, the write level and the read level both equal the true number of stored words.
- R7: On each side, empty means level == 0, almost-empty means level <= `AEMPTY_TH`, half-full means level >= DEPTH/2, and almost-full means level >= `AFULL_TH`.
- R8: Each registered Gray pointer changes by at most one bit from one cycle of its own clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain reset, asynchronous active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_level | output | ADDR_W+1 | Fill count seen by the write side |
| wr_full | output | 1 | Write side: storage full |
| wr_afull | output | 1 | Write side: level >= AFULL_TH |
| wr_half | output | 1 | Write side: level >= DEPTH/2 |
| wr_aempty | output | 1 | Write side: level <= AEMPTY_TH |
| wr_empty | output | 1 | Write side: level == 0 |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain reset, asynchronous active low |
| rd_en | input | 1 | Read (pop) request |
| rd_data | output | DATA_W | Oldest stored word |
| rd_level | output | ADDR_W+1 | Fill count seen by the read side |
| rd_full | output | 1 | Read side: storage full |
| rd_afull | output | 1 | Read side: level >= AFULL_TH |
| rd_half | output | 1 | Read side: level >= DEPTH/2 |
| rd_aempty | output | 1 | Read side: level <= AEMPTY_TH |
| rd_empty | output | 1 | Read side: level == 0 |

## Verification
The bench uses the defaults: 8-bit data, `ADDR_W` = 3 (eight words), a two-stage synchronizer, `AFULL_TH` = 6 and `AEMPTY_TH` = 2. With only eight entries, a directed fill can step through every level from 0 to full and back to 0, checking all five flags on both sides at each step. Random traffic at unrelated clock rates also reaches full and empty often, so pointer wrap-around and the modulo subtraction are exercised many times. The write clock is 4 ns and the read clock is 6.6 ns, so the phase relation between the domains keeps drifting throughout the run.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Selects which pointer is the minuend in the level computation
  typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} side_e;
endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q
);
  logic [PW-1:0] bin_nxt;
  logic [PW-1:0] gray_nxt;

  always_comb begin
    bin_nxt  = bin_q + {{(PW-1){1'b0}}, step};
    gray_nxt = bin_nxt ^ (bin_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (step) begin
      bin_q  <= bin_nxt;
      gray_q <= gray_nxt;
    end
  end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int STG = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] chain [STG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STG; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STG-1];
endmodule

// File: rtl/dcf_level.sv
module dcf_level
  import dcf_pkg::*;
#(
  parameter int    PW        = 4,
  parameter side_e SIDE      = SIDE_WR,
  parameter int    AFULL_TH  = 6,
  parameter int    AEMPTY_TH = 2
) (
  input  logic [PW-1:0] local_bin,
  input  logic [PW-1:0] remote_gray,
  output logic [PW-1:0] level,
  output logic          full,
  output logic          afull,
  output logic          half,
  output logic          aempty,
  output logic          empty
);
  localparam int            DEPTH = 1 << (PW - 1);
  localparam logic [PW-1:0] AF    = PW'(AFULL_TH);
  localparam logic [PW-1:0] AE    = PW'(AEMPTY_TH);
  localparam logic [PW-1:0] HF    = PW'(DEPTH / 2);

  logic [PW-1:0] remote_bin;

  always_comb begin
    remote_bin[PW-1] = remote_gray[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      remote_bin[i] = remote_bin[i+1] ^ remote_gray[i];
    end
  end

  if (SIDE == SIDE_WR) begin : g_wr
    assign level = local_bin - remote_bin;
  end else begin : g_rd
    assign level = remote_bin - local_bin;
  end

  always_comb begin
    full   = level[PW-1];
    empty  = (level == '0);
    afull  = (level >= AF);
    aempty = (level <= AE);
    half   = (level >= HF);
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcfifo_lvl.sv
module dcfifo_lvl
  import dcf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int AFULL_TH    = 6,
  parameter int AEMPTY_TH   = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W:0]   wr_level,
  output logic              wr_full,
  output logic              wr_afull,
  output logic              wr_half,
  output logic              wr_aempty,
  output logic              wr_empty,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W:0]   rd_level,
  output logic              rd_full,
  output logic              rd_afull,
  output logic              rd_half,
  output logic              rd_aempty,
  output logic              rd_empty
);
  localparam int PW = ADDR_W + 1;

  logic          wr_step, rd_step;
  logic [PW-1:0] wr_bin_q, wr_gray_q, rd_bin_q, rd_gray_q;
  logic [PW-1:0] wr_gray_in_rd, rd_gray_in_wr;

  assign wr_step = wr_en & ~wr_full;
  assign rd_step = rd_en & ~rd_empty;

  dcf_ptr #(.PW(PW)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .step(wr_step),
    .bin_q(wr_bin_q), .gray_q(wr_gray_q)
  );

  dcf_ptr #(.PW(PW)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .step(rd_step),
    .bin_q(rd_bin_q), .gray_q(rd_gray_q)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray_q), .q(wr_gray_in_rd)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray_q), .q(rd_gray_in_wr)
  );

  dcf_level #(.PW(PW), .SIDE(SIDE_WR), .AFULL_TH(AFULL_TH), .AEMPTY_TH(AEMPTY_TH)) u_wlvl (
    .local_bin(wr_bin_q), .remote_gray(rd_gray_in_wr), .level(wr_level),
    .full(wr_full), .afull(wr_afull), .half(wr_half), .aempty(wr_aempty), .empty(wr_empty)
  );

  dcf_level #(.PW(PW), .SIDE(SIDE_RD), .AFULL_TH(AFULL_TH), .AEMPTY_TH(AEMPTY_TH)) u_rlvl (
    .local_bin(rd_bin_q), .remote_gray(wr_gray_in_rd), .level(rd_level),
    .full(rd_full), .afull(rd_afull), .half(rd_half), .aempty(rd_aempty), .empty(rd_empty)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_step), .waddr(wr_bin_q[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(rd_bin_q[ADDR_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int PW    = 4,
  parameter int DEPTH = 8
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          wr_full,
  input logic          rd_empty,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] rd_level,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray
);
  assert_wr_bound_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_level <= PW'(DEPTH));

  assert_rd_bound_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_level <= PW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && wr_en) |=> (wr_level <= $past(wr_level)));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && rd_en) |=> (rd_level >= $past(rd_level)));

  assert_wgray_step_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_rgray_step_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dcfifo_lvl dcf_checker #(.PW(ADDR_W + 1), .DEPTH(1 << ADDR_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .wr_full(wr_full), .rd_empty(rd_empty),
  .wr_level(wr_level), .rd_level(rd_level),
  .wr_gray(wr_gray_q), .rd_gray(rd_gray_q)
);

// File: tb/dcfifo_lvl_tb.sv
`timescale 1ns/1ps
module dcfifo_lvl_tb;
  localparam int DW = 8, AW = 3, DEPTH = 1 << AW, AFT = 6, AET = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [AW:0] wr_level, rd_level;
  logic wr_full, wr_afull, wr_half, wr_aempty, wr_empty;
  logic rd_full, rd_afull, rd_half, rd_aempty, rd_empty;

  int checks = 0, fails = 0;
  logic [DW-1:0] q [$];
  bit wdone = 1'b0;

  always #2   wr_clk = ~wr_clk;
  always #3.3 rd_clk = ~rd_clk;

  dcfifo_lvl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .AFULL_TH(AFT), .AEMPTY_TH(AET)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_level(wr_level), .wr_full(wr_full), .wr_afull(wr_afull), .wr_half(wr_half),
    .wr_aempty(wr_aempty), .wr_empty(wr_empty),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_level(rd_level), .rd_full(rd_full), .rd_afull(rd_afull), .rd_half(rd_half),
    .rd_aempty(rd_aempty), .rd_empty(rd_empty)
  );

  function automatic logic [4:0] exp_flags(int lvl);
    // {full, afull, half, aempty, empty}
    return {lvl == DEPTH, lvl >= AFT, lvl >= DEPTH / 2, lvl <= AET, lvl == 0};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6/R7/R5: both sides settled on the same level with matching flags
  task automatic chk_level(string req, int n);
    @(negedge wr_clk);
    chk({req, " R6 wr_level"}, int'(wr_level), n);
    chk({req, " R7 wr_flags"}, int'({wr_full, wr_afull, wr_half, wr_aempty, wr_empty}), int'(exp_flags(n)));
    @(negedge rd_clk);
    chk({req, " R6 rd_level"}, int'(rd_level), n);
    chk({req, " R7 rd_flags"}, int'({rd_full, rd_afull, rd_half, rd_aempty, rd_empty}), int'(exp_flags(n)));
  endtask

  task automatic settle();
    repeat (20) @(negedge wr_clk);
  endtask

  task automatic push(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    if (!wr_full) q.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    if (!rd_empty) begin
      logic [DW-1:0] e;
      e = q.pop_front();
      chk("R2 data", int'(rd_data), int'(e));
    end
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1'b1;
    @(negedge rd_clk);
    rd_rst_n = 1'b1;
    chk_level("R1 reset", 0);

    // R4: reads while empty are dropped
    repeat (3) pop();
    settle();
    chk_level("R4 after empty reads", 0);

    // Fill step by step
    for (int i = 1; i <= DEPTH; i++) begin
      push(DW'(8'hA0 + i));
      settle();
      chk_level("R7 fill", i);
    end

    // R3: writes while full are dropped
    push(8'h55);
    push(8'h66);
    settle();
    chk_level("R3 after full writes", DEPTH);
    chk("R3 model depth", q.size(), DEPTH);

    // Drain step by step; the first word proves R4 left the read pointer alone
    for (int i = DEPTH - 1; i >= 0; i--) begin
      pop();
      settle();
      chk_level("R7 drain", i);
    end

    // Random traffic with unrelated clocks
    fork
      begin
        for (int k = 0; k < 800; k++) begin
          @(negedge wr_clk);
          wr_en = (($urandom % 4) != 0);
          wr_data = DW'($urandom);
          if (wr_en && !wr_full) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        wdone = 1'b1;
      end
      begin
        while (!(wdone && q.size() == 0)) begin
          @(negedge rd_clk);
          rd_en = (($urandom % 3) != 0);
          if (rd_en && !rd_empty) begin
            logic [DW-1:0] e;
            e = q.pop_front();
            chk("R2 random data", int'(rd_data), int'(e));
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
    settle();
    chk_level("R2 final", 0);
    finish_run();
  end
endmodule